// File: doc/BRIEF.md
# Single Stuck-At Fault Injector

The block holds a fixed four-input netlist of two AND gates feeding an OR gate, so its fault-free output is AB + CD. Two copies run side by side. The good copy is never disturbed. The faulty copy can hold exactly one of its lines at a constant 0 or 1. A test pattern applied to the four primary inputs therefore shows at once whether it exposes the selected fault. This lets pattern sets be graded one fault at a time.

There are 13 addressable lines:

- the four primary-input stems;
- the four AND input pins;
- the two AND outputs;
- the two OR input pins;
- the final output.

Each line has two possible stuck values, which gives 26 single faults. A fault is exposed only when the pattern drives the chosen line to the opposite of its stuck value and the change reaches the output. The exposure is either good 1 / faulty 0 or good 0 / faulty 1. The comparison is combinational. It is registered into a per-cycle detect flag and into a sticky flag.

The sticky flag is a two-state machine:

- **TRK_CLEAN**: no mismatch has been seen since reset or the last clear.
- **TRK_CAUGHT**: at least one mismatch has been seen.

Its transitions are:

- **hit**: TRK_CLEAN to TRK_CAUGHT, taken on a sampled mismatch when clear is low.
- **hold**: TRK_CAUGHT stays in TRK_CAUGHT while clear is low.
- **clear**: any state goes to TRK_CLEAN while clear is high. Clear wins over a mismatch in the same cycle.

Top module: `stuckat_injector`

## Requirements
- R1: `good_z` always equals (A AND B) OR (C AND D), whatever the fault controls hold.
- R2: With `flt_en` low, `faulty_z` equals `good_z` for every site and stuck value.
- R3: A site code of 13 or above leaves `faulty_z` equal to `good_z` even with `flt_en` high.
- R4: These site codes force the A or B operand of the first AND term to the stuck value:
  - codes 0 and 4 force the A operand;
  - codes 1 and 5 force the B operand.

  Code 0 is the A stem, 4 is the A pin, 1 is the B stem and 5 is the B pin. The C/D term is unchanged.
- R5: These site codes force the C or D operand of the second AND term:
  - codes 2 and 6 force the C operand (stem and pin);
  - codes 3 and 7 force the D operand (stem and pin).

  For example, C stuck at 1 gives AB + D, and D stuck at 0 gives AB.
- R6: These site codes replace a whole AND term by the stuck value:
  - codes 8 (first AND output) and 10 (its OR pin) replace the AB term;
  - codes 9 and 11 do the same for the CD term.
- R7: Site code 12 (the output line) makes `faulty_z` equal the stuck value.
- R8: `detect` is high in the cycle after a clock edge at which `good_z` and `faulty_z` differed, and low after an edge at which they matched.
- R9: `detect_sticky` goes high after the first sampled mismatch and stays high until `sticky_clr` is sampled high. `sticky_clr` wins over a mismatch in the same cycle.
- R10: While and just after reset, `detect` and `detect_sticky` are 0 (state TRK_CLEAN).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_a | input | 1 | Primary input A |
| in_b | input | 1 | Primary input B |
| in_c | input | 1 | Primary input C |
| in_d | input | 1 | Primary input D |
| flt_en | input | 1 | Enables the selected fault |
| flt_site | input | SITE_W | Line to force (codes 0..12) |
| flt_val | input | 1 | Stuck value |
| sticky_clr | input | 1 | Synchronous clear of the sticky flag |
| good_z | output | 1 | Fault-free output |
| faulty_z | output | 1 | Output of the faulted copy |
| detect | output | 1 | Registered mismatch flag |
| detect_sticky | output | 1 | Sticky mismatch flag |

## Verification
The bench builds the block with the default SITE_W of 4. At that width the codes 13 to 15 exist on the port, so the out-of-range path is reachable and is tested. Every site is swept with both stuck values over all 16 input patterns. This covers the stated AB and AB + D cases and every term-replacement case. Random vectors with occasional clears then exercise the hit, hold and clear transitions, including a clear that lands on a mismatch.

// File: rtl/stuckat_pkg.sv
package stuckat_pkg;
    // Line codes of the fixed netlist z = AB + CD
    localparam int SITE_STEM_A  = 0;
    localparam int SITE_STEM_B  = 1;
    localparam int SITE_STEM_C  = 2;
    localparam int SITE_STEM_D  = 3;
    localparam int SITE_PIN_A   = 4;
    localparam int SITE_PIN_B   = 5;
    localparam int SITE_PIN_C   = 6;
    localparam int SITE_PIN_D   = 7;
    localparam int SITE_AND1_Y  = 8;
    localparam int SITE_AND2_Y  = 9;
    localparam int SITE_OR_P    = 10;
    localparam int SITE_OR_Q    = 11;
    localparam int SITE_OUT     = 12;
    localparam int NUM_SITES    = 13;
    localparam int NUM_PI       = 4;

    typedef enum logic {
        TRK_CLEAN  = 1'b0,
        TRK_CAUGHT = 1'b1
    } trk_state_e;
endpackage

// File: rtl/stuckat_line.sv
module stuckat_line #(
    parameter int SITE_W = 4,
    parameter int LINE_ID = 0
) (
    input  logic              line_in,
    input  logic              force_en,
    input  logic [SITE_W-1:0] force_site,
    input  logic              force_val,
    output logic              line_out
);
    localparam logic [SITE_W-1:0] MY_CODE = SITE_W'(LINE_ID);

    always_comb begin
        line_out = line_in;
        if (force_en && (force_site == MY_CODE)) begin
            line_out = force_val;
        end
    end
endmodule

// File: rtl/stuckat_netlist.sv
module stuckat_netlist
    import stuckat_pkg::*;
#(
    parameter int SITE_W = 4
) (
    input  logic [NUM_PI-1:0] pi,
    input  logic              force_en,
    input  logic [SITE_W-1:0] force_site,
    input  logic              force_val,
    output logic              z
);
    logic [NUM_PI-1:0] stem;
    logic [NUM_PI-1:0] pin;
    logic and1_raw, and2_raw, and1_y, and2_y;
    logic or_p, or_q, or_raw;

    // Primary-input stems and the AND pins they feed
    for (genvar i = 0; i < NUM_PI; i++) begin : g_in
        stuckat_line #(.SITE_W(SITE_W), .LINE_ID(SITE_STEM_A + i)) u_stem (
            .line_in(pi[i]), .force_en(force_en), .force_site(force_site),
            .force_val(force_val), .line_out(stem[i])
        );
        stuckat_line #(.SITE_W(SITE_W), .LINE_ID(SITE_PIN_A + i)) u_pin (
            .line_in(stem[i]), .force_en(force_en), .force_site(force_site),
            .force_val(force_val), .line_out(pin[i])
        );
    end

    assign and1_raw = pin[0] & pin[1];
    assign and2_raw = pin[2] & pin[3];

    stuckat_line #(.SITE_W(SITE_W), .LINE_ID(SITE_AND1_Y)) u_and1_y (
        .line_in(and1_raw), .force_en(force_en), .force_site(force_site),
        .force_val(force_val), .line_out(and1_y)
    );
    stuckat_line #(.SITE_W(SITE_W), .LINE_ID(SITE_AND2_Y)) u_and2_y (
        .line_in(and2_raw), .force_en(force_en), .force_site(force_site),
        .force_val(force_val), .line_out(and2_y)
    );
    stuckat_line #(.SITE_W(SITE_W), .LINE_ID(SITE_OR_P)) u_or_p (
        .line_in(and1_y), .force_en(force_en), .force_site(force_site),
        .force_val(force_val), .line_out(or_p)
    );
    stuckat_line #(.SITE_W(SITE_W), .LINE_ID(SITE_OR_Q)) u_or_q (
        .line_in(and2_y), .force_en(force_en), .force_site(force_site),
        .force_val(force_val), .line_out(or_q)
    );

    assign or_raw = or_p | or_q;

    stuckat_line #(.SITE_W(SITE_W), .LINE_ID(SITE_OUT)) u_out (
        .line_in(or_raw), .force_en(force_en), .force_site(force_site),
        .force_val(force_val), .line_out(z)
    );
endmodule

// File: rtl/stuckat_track.sv
module stuckat_track
    import stuckat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic miss,
    input  logic clr,
    output logic detect,
    output logic sticky
);
    trk_state_e state_q, state_d;
    logic       detect_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= TRK_CLEAN;
            detect_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            detect_q <= miss;
        end
    end

    // Next state: clear, hit, hold
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRK_CLEAN: begin
                if (clr)       state_d = TRK_CLEAN;
                else if (miss) state_d = TRK_CAUGHT;
            end
            TRK_CAUGHT: begin
                if (clr)       state_d = TRK_CLEAN;
            end
            default:           state_d = TRK_CLEAN;
        endcase
    end

    // Outputs
    always_comb begin
        detect = detect_q;
        sticky = (state_q == TRK_CAUGHT);
    end
endmodule

// File: rtl/stuckat_injector.sv
module stuckat_injector
    import stuckat_pkg::*;
#(
    parameter int SITE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_a,
    input  logic              in_b,
    input  logic              in_c,
    input  logic              in_d,
    input  logic              flt_en,
    input  logic [SITE_W-1:0] flt_site,
    input  logic              flt_val,
    input  logic              sticky_clr,
    output logic              good_z,
    output logic              faulty_z,
    output logic              detect,
    output logic              detect_sticky
);
    localparam int MIN_SITE_W = $clog2(NUM_SITES);

    logic [NUM_PI-1:0] pi_vec;

    assign pi_vec = {in_d, in_c, in_b, in_a};

    initial begin
        if (SITE_W < MIN_SITE_W) $display("stuckat_injector: SITE_W too narrow");
    end

    stuckat_netlist #(.SITE_W(SITE_W)) u_good (
        .pi(pi_vec), .force_en(1'b0), .force_site(flt_site),
        .force_val(flt_val), .z(good_z)
    );

    stuckat_netlist #(.SITE_W(SITE_W)) u_bad (
        .pi(pi_vec), .force_en(flt_en), .force_site(flt_site),
        .force_val(flt_val), .z(faulty_z)
    );

    stuckat_track u_track (
        .clk(clk), .rst_n(rst_n), .miss(good_z ^ faulty_z),
        .clr(sticky_clr), .detect(detect), .sticky(detect_sticky)
    );
endmodule

// File: rtl/stuckat_injector_chk.sv
module stuckat_injector_chk
    import stuckat_pkg::*;
#(
    parameter int SITE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_a,
    input logic              in_b,
    input logic              in_c,
    input logic              in_d,
    input logic              flt_en,
    input logic [SITE_W-1:0] flt_site,
    input logic              flt_val,
    input logic              sticky_clr,
    input logic              good_z,
    input logic              faulty_z,
    input logic              detect,
    input logic              detect_sticky
);
    localparam logic [SITE_W-1:0] LAST_CODE = SITE_W'(NUM_SITES - 1);
    localparam logic [SITE_W-1:0] OUT_CODE  = SITE_W'(SITE_OUT);

    a_r1_good_function: assert property (@(posedge clk) disable iff (!rst_n)
        good_z == ((in_a & in_b) | (in_c & in_d)));

    a_r2_disabled_match: assert property (@(posedge clk) disable iff (!rst_n)
        !flt_en |-> (faulty_z == good_z));

    a_r3_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_site > LAST_CODE) |-> (faulty_z == good_z));

    a_r7_output_site: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_en && flt_site == OUT_CODE) |-> (faulty_z == flt_val));

    a_r8_detect_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (good_z != faulty_z) |=> detect);

    a_r8_detect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (good_z == faulty_z) |=> !detect);

    a_r9_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (detect_sticky && !sticky_clr) |=> detect_sticky);

    a_r9_sticky_clear: assert property (@(posedge clk) disable iff (!rst_n)
        sticky_clr |=> !detect_sticky);
endmodule

bind stuckat_injector stuckat_injector_chk #(.SITE_W(SITE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b), .in_c(in_c),
    .in_d(in_d), .flt_en(flt_en), .flt_site(flt_site), .flt_val(flt_val),
    .sticky_clr(sticky_clr), .good_z(good_z), .faulty_z(faulty_z),
    .detect(detect), .detect_sticky(detect_sticky)
);

// File: tb/stuckat_injector_bench.sv
module stuckat_injector_bench;
    localparam int SITE_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_a = 0, in_b = 0, in_c = 0, in_d = 0;
    logic flt_en = 0, flt_val = 0, sticky_clr = 0;
    logic [SITE_W-1:0] flt_site = '0;
    logic good_z, faulty_z, detect, detect_sticky;

    int n_chk = 0;
    int n_bad = 0;
    logic exp_sticky = 1'b0;

    always #2 clk = ~clk;

    stuckat_injector #(.SITE_W(SITE_W)) u_stuckat_injector (
        .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b), .in_c(in_c),
        .in_d(in_d), .flt_en(flt_en), .flt_site(flt_site), .flt_val(flt_val),
        .sticky_clr(sticky_clr), .good_z(good_z), .faulty_z(faulty_z),
        .detect(detect), .detect_sticky(detect_sticky)
    );

    function automatic logic exp_good(logic a, logic b, logic c, logic d);
        return (a & b) | (c & d);
    endfunction

    function automatic logic exp_bad(logic a, logic b, logic c, logic d,
                                     logic en, int site, logic sv);
        logic t1, t2;
        t1 = a & b;
        t2 = c & d;
        if (!en || site > 12) return t1 | t2;
        case (site)
            0, 4:   t1 = sv & b;
            1, 5:   t1 = a & sv;
            2, 6:   t2 = sv & d;
            3, 7:   t2 = c & sv;
            8, 10:  t1 = sv;
            9, 11:  t2 = sv;
            default: return sv;
        endcase
        return t1 | t2;
    endfunction

    task automatic check(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic string site_req(logic en, int site);
        if (!en) return "R2";
        if (site > 12) return "R3";
        if (site == 0 || site == 1 || site == 4 || site == 5) return "R4";
        if (site == 2 || site == 3 || site == 6 || site == 7) return "R5";
        if (site == 12) return "R7";
        return "R6";
    endfunction

    // Apply one vector after a negedge, check combinational, then registered outputs
    task automatic apply(logic [3:0] abcd, logic en, int site, logic sv, logic clr);
        logic g, f;
        @(negedge clk);
        {in_d, in_c, in_b, in_a} = abcd;
        flt_en = en;
        flt_site = SITE_W'(site);
        flt_val = sv;
        sticky_clr = clr;
        #1;
        g = exp_good(abcd[0], abcd[1], abcd[2], abcd[3]);
        f = exp_bad(abcd[0], abcd[1], abcd[2], abcd[3], en, site, sv);
        check("R1", good_z, g);
        check(site_req(en, site), faulty_z, f);
        @(posedge clk);
        #1;
        exp_sticky = clr ? 1'b0 : (exp_sticky | (g ^ f));
        check("R8", detect, g ^ f);
        check("R9", detect_sticky, exp_sticky);
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd5381));
        repeat (3) @(posedge clk);
        #1;
        check("R10", detect, 1'b0);
        check("R10", detect_sticky, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // Stated cases: C/D term removed by D stuck at 0 -> AB; C stuck at 1 -> AB + D
        apply(4'b1100, 1'b1, 3, 1'b0, 1'b0);
        apply(4'b1011, 1'b1, 2, 1'b1, 1'b0);

        // Clear wins over a simultaneous mismatch
        apply(4'b1100, 1'b1, 12, 1'b0, 1'b1);

        // Exhaustive sweep: every site code incl. out-of-range, both values, enable both ways
        for (int en = 0; en < 2; en++) begin
            for (int s = 0; s < 16; s++) begin
                for (int v = 0; v < 2; v++) begin
                    for (int p = 0; p < 16; p++) begin
                        apply(4'(p), 1'(en), s, 1'(v), (p == 0));
                    end
                end
            end
        end

        // Random mix
        for (int k = 0; k < 600; k++) begin
            apply(4'($urandom_range(15)), 1'($urandom_range(1)),
                  int'($urandom_range(15)), 1'($urandom_range(1)),
                  ($urandom_range(15) == 0));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule